// File: doc/BRIEF.md
# Packed Byte Sum-of-Absolute-Differences Engine

This block scores how closely two groups of eight pixels match. It is the inner step of block-matching motion estimation. Each operand word packs eight unsigned bytes. The engine subtracts the two bytes in each position and takes the magnitude of each difference. It then adds all eight magnitudes and returns the total in the low 16 bits of a 64-bit result word.

The work runs in three register stages:
- a 9-bit signed difference for each lane;
- a magnitude for each lane;
- a carry-save compressor tree, of the kind used to reduce multiplier partial products, followed by one carry-propagate add.

Operands enter and results leave through valid/ready handshakes. The pipeline accepts one operand pair per cycle as long as the consumer keeps up. When the consumer stalls, all three stages freeze together.

Top module: `psad_engine`

## Requirements
- R1: Byte lane k of an operand occupies bits [8k+7:8k], for k = 0 to 7. Every lane is treated as an unsigned value from 0 to 255, and the lanes are independent.
- R2: out_data[15:0] equals the sum over all eight lanes of |a_k - b_k|.
- R3: out_data[63:16] is zero whenever out_valid is high.
- R4: The result never exceeds 2040. It reaches 2040 exactly when one operand is all 0xFF and the other all 0x00, in either order. Swapping the two operands leaves the result unchanged.
- R5: Let an operand pair be accepted at a rising edge while out_ready stays high. out_valid is then low after the first and second following edges and high after the third edge counting the accepting one, carrying that pair's result.
- R6: With out_ready held high, in_ready stays high, so one pair is accepted on every cycle. Results leave in the order the operands entered.
- R7: While out_valid is high and out_ready is low, in_ready is low.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold their values into the next cycle. Every accepted pair yields exactly one result, with nothing dropped or repeated.
- R9: After reset, out_valid is low and in_ready is high.
- R10: A cycle with in_valid low creates no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Engine can accept an operand pair this cycle |
| in_a | input | 64 | First operand, eight unsigned bytes |
| in_b | input | 64 | Second operand, eight unsigned bytes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Sum of absolute differences in bits [15:0], zero above |

## Verification
The bench builds the engine with its default parameters: eight 8-bit lanes, a 16-bit result field and the select-based magnitude variant. With eight lanes, the compressor tree has four levels (8 to 6 to 4 to 3 to 2 operands), so every level and the pass-through of remainders is exercised.

Byte values are only 8 bits wide, so all 65,536 byte pairs can be applied, copied into every lane. This reaches every difference sign, both magnitude extremes and the 2040 ceiling. A sweep over each lane position alone and a randomized phase with consumer stalls and input bubbles then cover lane placement, freezing of the pipeline and result ordering.

// File: rtl/psad_pkg.sv
package psad_pkg;

   // How each lane turns its signed difference into a magnitude
   typedef enum logic {
      MAG_SELECT = 1'b0,   // pick the difference or its negation by sign
      MAG_INVERT = 1'b1    // invert by sign, then add the sign bit back
   } mag_style_e;

   // Operands left after one level of 3:2 compressors
   function automatic int csa_next(input int n);
      return (n / 3) * 2 + (n % 3);
   endfunction

   // Operands present at tree level lvl, starting from n
   function automatic int csa_count(input int n, input int lvl);
      int c;
      c = n;
      for (int i = 0; i < lvl; i++) begin
         if (c > 2) c = csa_next(c);
      end
      return c;
   endfunction

   // Number of compressor levels needed to reach two operands
   function automatic int csa_depth(input int n);
      int c;
      int d;
      c = n;
      d = 0;
      while (c > 2) begin
         c = csa_next(c);
         d++;
      end
      return d;
   endfunction

endpackage

// File: rtl/psad_lane_diff.sv
module psad_lane_diff #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic [LANE_W:0]   lane_diff
);
   // One extra bit keeps the sign of the unsigned subtraction
   always_comb begin
      lane_diff = {1'b0, lane_a} - {1'b0, lane_b};
   end
endmodule

// File: rtl/psad_lane_mag.sv
module psad_lane_mag #(
   parameter int                   LANE_W    = 8,
   parameter psad_pkg::mag_style_e MAG_STYLE = psad_pkg::MAG_SELECT
) (
   input  logic [LANE_W:0]   lane_diff,
   output logic [LANE_W-1:0] lane_mag
);
   logic             neg;
   logic [LANE_W-1:0] low;

   assign neg = lane_diff[LANE_W];
   assign low = lane_diff[LANE_W-1:0];

   generate
      if (MAG_STYLE == psad_pkg::MAG_SELECT) begin : g_select
         always_comb begin
            lane_mag = neg ? (~low + LANE_W'(1)) : low;
         end
      end else begin : g_invert
         always_comb begin
            lane_mag = (low ^ {LANE_W{neg}}) + LANE_W'(neg);
         end
      end
   endgenerate
endmodule

// File: rtl/psad_csa_tree.sv
module psad_csa_tree #(
   parameter int N_OPS = 8,
   parameter int W     = 11
) (
   input  logic [N_OPS*W-1:0] ops_flat,
   output logic [W-1:0]       total
);
   localparam int DEPTH = psad_pkg::csa_depth(N_OPS);

   logic [W-1:0] lvl [DEPTH+1][N_OPS];

   generate
      if (N_OPS < 2) begin : g_bad_n
         $error("psad_csa_tree needs at least two operands");
      end

      for (genvar k = 0; k < N_OPS; k++) begin : g_in
         assign lvl[0][k] = ops_flat[k*W +: W];
      end

      for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
         localparam int N_HERE  = psad_pkg::csa_count(N_OPS, l);
         localparam int GROUPS  = N_HERE / 3;
         localparam int N_NEXT  = psad_pkg::csa_next(N_HERE);
         for (genvar k = 0; k < N_OPS; k++) begin : g_out
            if (k < 2 * GROUPS) begin : g_csa
               localparam int G = k / 2;
               if (k % 2 == 0) begin : g_sum
                  assign lvl[l+1][k] = lvl[l][3*G] ^ lvl[l][3*G+1] ^ lvl[l][3*G+2];
               end else begin : g_carry
                  assign lvl[l+1][k] = ((lvl[l][3*G] & lvl[l][3*G+1]) |
                                        (lvl[l][3*G] & lvl[l][3*G+2]) |
                                        (lvl[l][3*G+1] & lvl[l][3*G+2])) << 1;
               end
            end else if (k < N_NEXT) begin : g_pass
               assign lvl[l+1][k] = lvl[l][3*GROUPS + (k - 2*GROUPS)];
            end else begin : g_zero
               assign lvl[l+1][k] = '0;
            end
         end
      end
   endgenerate

   // Single carry-propagate add closes the reduction
   always_comb begin
      total = lvl[DEPTH][0] + lvl[DEPTH][1];
   end
endmodule

// File: rtl/psad_engine.sv
module psad_engine #(
   parameter int                   LANES     = 8,
   parameter int                   LANE_W    = 8,
   parameter int                   RES_W     = 16,
   parameter psad_pkg::mag_style_e MAG_STYLE = psad_pkg::MAG_SELECT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES*LANE_W-1:0] in_a,
   input  logic [LANES*LANE_W-1:0] in_b,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [LANES*LANE_W-1:0] out_data
);
   localparam int OUT_W  = LANES * LANE_W;
   localparam int DIFF_W = LANE_W + 1;
   localparam int SUM_W  = $clog2(LANES * ((1 << LANE_W) - 1) + 1);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("psad_engine needs at least two lanes");
      end
      if (LANE_W < 2) begin : g_bad_lane_w
         $error("psad_engine lanes must be at least two bits");
      end
      if (SUM_W > RES_W) begin : g_bad_res
         $error("result field too narrow for the largest sum");
      end
      if (RES_W > OUT_W) begin : g_bad_out
         $error("result field wider than the output word");
      end
   endgenerate

   // Global stall: every stage moves only when the output can move
   logic advance;
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   // ---------------- stage 1: lane differences ----------------
   logic [LANES*DIFF_W-1:0] diff_c;
   logic [LANES*DIFF_W-1:0] s1_diff;
   logic                    s1_v;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_diff
         psad_lane_diff #(.LANE_W(LANE_W)) u_diff (
            .lane_a   (in_a[k*LANE_W +: LANE_W]),
            .lane_b   (in_b[k*LANE_W +: LANE_W]),
            .lane_diff(diff_c[k*DIFF_W +: DIFF_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
      end else if (advance) begin
         s1_v <= in_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (advance && in_valid) begin
         s1_diff <= diff_c;
      end
   end

   // ---------------- stage 2: lane magnitudes ----------------
   logic [LANES*LANE_W-1:0] mag_c;
   logic [LANES*LANE_W-1:0] s2_mag;
   logic                    s2_v;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_mag
         psad_lane_mag #(.LANE_W(LANE_W), .MAG_STYLE(MAG_STYLE)) u_mag (
            .lane_diff(s1_diff[k*DIFF_W +: DIFF_W]),
            .lane_mag (mag_c[k*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_v <= 1'b0;
      end else if (advance) begin
         s2_v <= s1_v;
      end
   end

   always_ff @(posedge clk) begin
      if (advance && s1_v) begin
         s2_mag <= mag_c;
      end
   end

   // ---------------- stage 3: compressor tree and final add ----------------
   logic [LANES*SUM_W-1:0] tree_in;
   logic [SUM_W-1:0]       tree_sum;
   logic [SUM_W-1:0]       s3_sum;
   logic                   s3_v;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_ext
         assign tree_in[k*SUM_W +: SUM_W] = SUM_W'(s2_mag[k*LANE_W +: LANE_W]);
      end
   endgenerate

   psad_csa_tree #(.N_OPS(LANES), .W(SUM_W)) u_tree (
      .ops_flat(tree_in),
      .total   (tree_sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s3_v <= 1'b0;
      end else if (advance) begin
         s3_v <= s2_v;
      end
   end

   always_ff @(posedge clk) begin
      if (advance && s2_v) begin
         s3_sum <= tree_sum;
      end
   end

   // ---------------- result packing ----------------
   assign out_valid = s3_v;
   assign out_data  = {{(OUT_W-RES_W){1'b0}}, RES_W'(s3_sum)};

endmodule

// File: rtl/psad_engine_chk.sv
module psad_engine_chk #(
   parameter int                   LANES     = 8,
   parameter int                   LANE_W    = 8,
   parameter int                   RES_W     = 16,
   parameter psad_pkg::mag_style_e MAG_STYLE = psad_pkg::MAG_SELECT
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [LANES*LANE_W-1:0] in_a,
   input logic [LANES*LANE_W-1:0] in_b,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [LANES*LANE_W-1:0] out_data
);
   localparam int OUT_W   = LANES * LANE_W;
   localparam int MAX_SUM = LANES * ((1 << LANE_W) - 1);

   logic fire_in;
   assign fire_in = in_valid && in_ready;

   // R3: nothing above the result field
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[OUT_W-1:RES_W] == '0));

   // R4: sum bounded by the all-extreme case
   a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[RES_W-1:0] <= RES_W'(MAX_SUM)));

   // R7: a blocked output closes the input
   a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R8: a blocked result stays put
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R5: accepted pair with an open path is visible three cycles later
   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fire_in, 3) && $past(in_ready, 2) && $past(in_ready, 1)) |-> out_valid);

   // R10: an empty pipeline with idle input yields no result
   a_r10_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(in_valid, 3) && !$past(in_valid, 2) && !$past(in_valid, 1) &&
       $past(in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1) && !$past(out_valid, 3)) |-> !out_valid);

   // R9: reset empties the pipeline
   a_r9_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_valid && in_ready));

endmodule

bind psad_engine psad_engine_chk #(
   .LANES(LANES), .LANE_W(LANE_W), .RES_W(RES_W), .MAG_STYLE(MAG_STYLE)
) u_chk (.*);

// File: tb/tb_psad_engine.sv
module tb_psad_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_data;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit stall_mode  = 1'b0;
   bit bubble_mode = 1'b0;
   bit done        = 1'b0;

   logic [63:0] expq[$];
   bit          stalled_prev = 1'b0;
   logic [63:0] prev_data = '0;

   always #10 clk = ~clk;   // 50 MHz

   psad_engine dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [63:0] sad_ref(input logic [63:0] a, input logic [63:0] b);
      int s;
      s = 0;
      for (int k = 0; k < 8; k++) begin
         int x;
         int y;
         x = int'(a[k*8 +: 8]);
         y = int'(b[k*8 +: 8]);
         s += (x > y) ? (x - y) : (y - x);
      end
      return 64'(s);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   // consumer readiness, refreshed at each falling edge
   always @(negedge clk) begin
      out_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
   end

   // monitor: samples one time unit after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (stalled_prev) begin
            check(out_valid && (out_data == prev_data), "R8 hold", out_data, prev_data);
         end
         if (out_valid && !out_ready) begin
            check(!in_ready, "R7 in_ready low while blocked", 64'(in_ready), 64'd0);
         end
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(1'b0, "R10 result without operands", out_data, 64'd0);
            end else begin
               logic [63:0] e;
               e = expq.pop_front();
               check(out_data == e, "R2/R3 result", out_data, e);
            end
         end
         if (in_valid && in_ready) expq.push_back(sad_ref(in_a, in_b));
         stalled_prev = out_valid && !out_ready;
         prev_data    = out_data;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         check(1'b0, "watchdog expired", 64'(cycles), 64'd0);
         finish_run();
      end
   end

   // call right after a falling edge; returns at the falling edge after acceptance
   task automatic send(input logic [63:0] a, input logic [63:0] b);
      if (bubble_mode && (($urandom % 3) == 0)) begin
         in_valid = 1'b0;
         @(negedge clk);
      end
      in_a = a;
      in_b = b;
      in_valid = 1'b1;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R9: reset state
      check(!out_valid, "R9 out_valid after reset", 64'(out_valid), 64'd0);
      check(in_ready, "R9 in_ready after reset", 64'(in_ready), 64'd1);
      @(negedge clk);

      // R5: latency of a single pair, output visible on the third falling edge
      send(64'h0102030405060708, 64'h0807060504030201);
      #2;
      check(!out_valid, "R5 not valid after 1 edge", 64'(out_valid), 64'd0);
      @(negedge clk); #2;
      check(!out_valid, "R5 not valid after 2 edges", 64'(out_valid), 64'd0);
      @(negedge clk); #2;
      check(out_valid, "R5 valid after 3 edges", 64'(out_valid), 64'd1);
      check(out_data == 64'd32, "R5 R1 result value", out_data, 64'd32);
      @(negedge clk);

      // R4: the extremes in both orders
      send({8{8'hFF}}, 64'd0);
      send(64'd0, {8{8'hFF}});
      repeat (4) @(negedge clk);

      // R6: back-to-back burst keeps in_ready high
      for (int i = 0; i < 8; i++) begin
         in_a = {8{8'(i * 37)}};
         in_b = {8{8'(255 - i)}};
         in_valid = 1'b1;
         #2;
         check(in_ready, "R6 in_ready during burst", 64'(in_ready), 64'd1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);

      // R2/R4: every byte pair, replicated into all lanes
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            send({8{8'(a)}}, {8{8'(b)}});
         end
      end

      // R1: each lane position on its own
      for (int k = 0; k < 8; k++) begin
         for (int v = 0; v < 4; v++) begin
            logic [63:0] a;
            logic [63:0] b;
            a = {8{8'h5A}};
            b = {8{8'h5A}};
            a[k*8 +: 8] = (v[0]) ? 8'hFF : 8'(v * 61);
            b[k*8 +: 8] = (v[0]) ? 8'h00 : 8'hC3;
            send(a, b);
            send(b, a);
         end
      end

      // R7/R8/R10: random operands with consumer stalls and idle inputs
      stall_mode  = 1'b1;
      bubble_mode = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         send({$urandom, $urandom}, {$urandom, $urandom});
      end
      bubble_mode = 1'b0;
      stall_mode  = 1'b0;

      // drain and confirm nothing was lost or left over
      repeat (10) @(negedge clk);
      #2;
      check(expq.size() == 0, "R8 every pair produced one result", 64'(expq.size()), 64'd0);
      check(!out_valid, "R10 idle after drain", 64'(out_valid), 64'd0);
      finish_run();
   end
endmodule